// File: doc/BRIEF.md
# Selectable-Tap Memory Delay Line

This block delays a one-bit modulated audio stream, the kind a delta-modulation converter produces, by storing it in a circular buffer of 12 288 one-bit cells. Each incoming sample is written at a write pointer. The sample that comes out is read from a point a fixed number of cells behind that pointer. The distance is one of six taps, picked by a 3-bit delay code: 2 000, 4 000, and so on up to 12 000 cells. At the fast sample rate (200 kHz) these taps give 10 to 60 ms in 10 ms steps. A slow mode takes a sample on only every second rate tick, so the same taps give 20 to 120 ms.

A mute input guards every change of configuration. While mute is high, the delay code and the rate mode are captured, and a sequencer fills the whole buffer with the idle pattern, which alternates 0 and 1. A done flag rises when the fill is complete. Outside that window the block ignores changes to the code or the mode. The output carries the idle pattern from reset onward. It switches to buffer data only after a full clear has completed and mute has been released. The buffer is held as 384 words of 32 cells, and the sequencer clears one word per clock.

Top module: `tap_delay_line`

## Requirements
- R1: After reset, `bit_vld_o`, `clear_done_o` and `bit_o` are 0. Until a clear completes, every sample gives the idle bit. The idle bit starts at 0 on the first sample after reset and inverts on every later sample, whether that sample is idle or not.
- R2: Mute high starts a clear. `clear_done_o` is 0 through the first 384 clock edges at which `mute_i` is high. It is 1 after the 385th such edge, and it stays 1 once mute is released.
- R3: In fast mode (`slow_i`=0), each `tick_i` sampled high is one sample. `bit_vld_o` pulses in the following cycle and in no other cycle. When running, `bit_o` then equals the `bit_i` value taken 2000×(code+1) samples earlier.
- R4: Delay codes 6 and 7 act as code 5, which selects the 12 000-cell tap.
- R5: After mute is released, sample k (counting from 0) reads a cleared cell until k reaches the tap offset. That sample returns bit 0 of k.
- R6: With `slow_i`=1 captured, only every second tick is a sample, beginning with the second tick after mute release. The tap is counted in samples, so the delay in ticks doubles.
- R7: Changes to `delay_code_i` or `slow_i` while `mute_i` is low have no effect on the delay or the rate.
- R8: While mute is high, and after a release that cuts a clear short, `clear_done_o` stays 0. Every sample returns the idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Rate tick at the fast sample rate |
| bit_i | input | 1 | Modulated input bit, taken on a sample |
| mute_i | input | 1 | System mute: captures settings and clears the buffer |
| slow_i | input | 1 | Rate mode, 1 = half rate; captured only under mute |
| delay_code_i | input | 3 | Tap select 0..5, with 6 and 7 clamped to 5; captured only under mute |
| bit_o | output | 1 | Delayed or idle output bit |
| bit_vld_o | output | 1 | One-cycle pulse marking each output sample |
| clear_done_o | output | 1 | Buffer fill with the idle pattern complete |

## Verification
Each sample's output bit and valid pulse appear one clock after the edge that takes the tick. The bench drives on the falling edge and pushes the expected bit into a queue on that edge. A monitor pops and compares it on the next falling edge, where `bit_vld_o` is high. The done flag is due on the 385th edge that sees mute high. The bench checks that it is still low one falling edge earlier and high on the falling edge after that 385th edge. A drain of a few cycles at the end of each run catches missing or surplus samples.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;
  // source of the output bit for one sample
  typedef enum logic {
    SRC_IDLE = 1'b0,
    SRC_MEM  = 1'b1
  } dl_src_e;

  // cell parity gives the idle pattern: even cells 0, odd cells 1
  function automatic logic idle_bit_of(input int unsigned idx);
    return 1'(idx % 2);
  endfunction
endpackage

// File: rtl/dl_rate_gate.sv
module dl_rate_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic slow_i,
  input  logic hold_i,
  output logic sample_o
);
  logic phase_q, phase_n;

  always_comb begin
    phase_n = phase_q;
    if (hold_i)                 phase_n = 1'b0;
    else if (tick_i && slow_i)  phase_n = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_n;
  end

  assign sample_o = tick_i & (~slow_i | phase_q);
endmodule

// File: rtl/dl_tap_select.sv
module dl_tap_select #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned NUM_TAPS = 6,
  parameter int unsigned TAP_STEP = 2000,
  parameter int unsigned AW       = 14
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [AW-1:0]     offset_o
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(NUM_TAPS - 1);

  logic [AW-1:0]     tap_tab [NUM_TAPS];
  logic [CODE_W-1:0] code_eff;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_tab[g] = AW'((g + 1) * TAP_STEP);
  end

  always_comb begin
    code_eff = (code_i > LAST) ? LAST : code_i;
    offset_o = tap_tab[code_eff];
  end
endmodule

// File: rtl/dl_clear_seq.sv
module dl_clear_seq #(
  parameter int unsigned NWORDS = 384,
  parameter int unsigned WAW    = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mute_i,
  output logic           mute_q_o,
  output logic           clr_we_o,
  output logic [WAW-1:0] clr_addr_o,
  output logic           done_o
);
  localparam logic [WAW-1:0] LAST_WORD = WAW'(NWORDS - 1);

  logic           mute_q, done_q, done_n;
  logic [WAW-1:0] cnt_q, cnt_n;
  logic           mute_rise, clr_we;

  assign mute_rise = mute_i & ~mute_q;
  assign clr_we    = mute_i & mute_q & ~done_q;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    if (mute_rise) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (clr_we) begin
      if (cnt_q == LAST_WORD) begin
        cnt_n  = '0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mute_q <= mute_i;
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  assign mute_q_o   = mute_q;
  assign clr_we_o   = clr_we;
  assign clr_addr_o = cnt_q;
  assign done_o     = done_q;
endmodule

// File: rtl/dl_bit_ram.sv
module dl_bit_ram import tap_delay_pkg::*; #(
  parameter int unsigned NWORDS = 384,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WAW    = 9,
  parameter int unsigned AW     = 14
) (
  input  logic              clk,
  input  logic              clr_we_i,
  input  logic [WAW-1:0]    clr_addr_i,
  input  logic              bit_we_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic              wr_bit_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int unsigned BW = AW - WAW;

  logic [WORD_W-1:0] mem [NWORDS];
  logic [WORD_W-1:0] idle_word;
  logic [WORD_W-1:0] rd_q;

  for (genvar j = 0; j < WORD_W; j++) begin : g_pat
    assign idle_word[j] = idle_bit_of(j);
  end

  always_ff @(posedge clk) begin
    if (clr_we_i)      mem[clr_addr_i] <= idle_word;
    else if (bit_we_i) mem[wr_addr_i[AW-1:BW]][wr_addr_i[BW-1:0]] <= wr_bit_i;
    if (rd_en_i)       rd_q <= mem[rd_addr_i[AW-1:BW]];
  end

  assign rd_word_o = rd_q;
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line import tap_delay_pkg::*; #(
  parameter int unsigned DEPTH_CELLS = 12288,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned TAP_STEP    = 2000,
  parameter int unsigned NUM_TAPS    = 6,
  parameter int unsigned CODE_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bit_i,
  input  logic              mute_i,
  input  logic              slow_i,
  input  logic [CODE_W-1:0] delay_code_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              clear_done_o
);
  localparam int unsigned NWORDS = DEPTH_CELLS / WORD_W;
  localparam int unsigned AW     = $clog2(DEPTH_CELLS);
  localparam int unsigned WAW    = $clog2(NWORDS);
  localparam int unsigned BW     = $clog2(WORD_W);
  localparam logic [AW-1:0] LAST_CELL = AW'(DEPTH_CELLS - 1);
  localparam logic [AW-1:0] DEPTH_A   = AW'(DEPTH_CELLS);

  // captured settings, loaded only while mute is high
  logic [CODE_W-1:0] cfg_code_q;
  logic              cfg_slow_q;

  logic              mute_q, clr_we, done, run, sample, mem_step;
  logic [WAW-1:0]    clr_addr;
  logic [AW-1:0]     tap_off, wr_q, wr_n, rd_addr;
  logic [WORD_W-1:0] rd_word;

  // output stage
  dl_src_e        src_q, src_n;
  logic [BW-1:0]  sel_q, sel_n;
  logic           idle_ph_q, idle_ph_n, idle_bit_q, idle_bit_n, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_code_q <= '0;
      cfg_slow_q <= 1'b0;
    end else if (mute_i) begin
      cfg_code_q <= delay_code_i;
      cfg_slow_q <= slow_i;
    end
  end

  dl_clear_seq #(.NWORDS(NWORDS), .WAW(WAW)) u_clear (
    .clk(clk), .rst_n(rst_n), .mute_i(mute_i), .mute_q_o(mute_q),
    .clr_we_o(clr_we), .clr_addr_o(clr_addr), .done_o(done)
  );

  dl_rate_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .slow_i(cfg_slow_q),
    .hold_i(mute_q), .sample_o(sample)
  );

  dl_tap_select #(.CODE_W(CODE_W), .NUM_TAPS(NUM_TAPS), .TAP_STEP(TAP_STEP), .AW(AW)) u_tap (
    .code_i(cfg_code_q), .offset_o(tap_off)
  );

  assign run      = done & ~mute_q;
  assign mem_step = sample & run;
  // result stays below DEPTH, so modular AW-bit arithmetic is exact
  assign rd_addr  = (wr_q >= tap_off) ? (wr_q - tap_off) : (wr_q + DEPTH_A - tap_off);

  always_comb begin
    wr_n = wr_q;
    if (mute_q)        wr_n = '0;
    else if (mem_step) wr_n = (wr_q == LAST_CELL) ? '0 : wr_q + 1'b1;
  end

  dl_bit_ram #(.NWORDS(NWORDS), .WORD_W(WORD_W), .WAW(WAW), .AW(AW)) u_ram (
    .clk(clk), .clr_we_i(clr_we), .clr_addr_i(clr_addr),
    .bit_we_i(mem_step), .wr_addr_i(wr_q), .wr_bit_i(bit_i),
    .rd_en_i(mem_step), .rd_addr_i(rd_addr), .rd_word_o(rd_word)
  );

  always_comb begin
    src_n      = src_q;
    sel_n      = sel_q;
    idle_bit_n = idle_bit_q;
    idle_ph_n  = idle_ph_q;
    if (sample) begin
      src_n      = run ? SRC_MEM : SRC_IDLE;
      sel_n      = rd_addr[BW-1:0];
      idle_bit_n = idle_ph_q;
      idle_ph_n  = ~idle_ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= '0;
      src_q      <= SRC_IDLE;
      sel_q      <= '0;
      idle_bit_q <= 1'b0;
      idle_ph_q  <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      wr_q       <= wr_n;
      src_q      <= src_n;
      sel_q      <= sel_n;
      idle_bit_q <= idle_bit_n;
      idle_ph_q  <= idle_ph_n;
      vld_q      <= sample;
    end
  end

  assign bit_o        = (src_q == SRC_MEM) ? rd_word[sel_q] : idle_bit_q;
  assign bit_vld_o    = vld_q;
  assign clear_done_o = done;
endmodule

// File: rtl/tap_delay_line_chk.sv
module tap_delay_line_chk #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned AW       = 14,
  parameter int unsigned TAP_STEP = 2000,
  parameter int unsigned NUM_TAPS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              mute_i,
  input logic              vld,
  input logic              done,
  input logic              cfg_slow,
  input logic [CODE_W-1:0] cfg_code,
  input logic [AW-1:0]     tap_off
);
  // R3: a valid pulse only follows a tick
  assert_vld_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(tick_i));

  // R2: a new mute drops the done flag on the next edge
  assert_done_drops_on_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_i && !$past(mute_i)) |=> !done);

  // R8: done can only come up while mute is held
  assert_done_needs_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mute_i));

  // R6: half rate never yields back-to-back samples
  assert_slow_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && cfg_slow && !mute_i) |=> !vld);

  // R7: settings move only under mute
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mute_i) |-> ($stable(cfg_code) && $stable(cfg_slow)));

  // R4: out-of-range codes clamp to the longest tap
  assert_clamp_longest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_code) >= NUM_TAPS) |-> (int'(tap_off) == NUM_TAPS * TAP_STEP));
endmodule

bind tap_delay_line tap_delay_line_chk #(
  .CODE_W(CODE_W), .AW(AW), .TAP_STEP(TAP_STEP), .NUM_TAPS(NUM_TAPS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mute_i(mute_i),
  .vld(bit_vld_o), .done(clear_done_o), .cfg_slow(cfg_slow_q),
  .cfg_code(cfg_code_q), .tap_off(tap_off)
);

// File: tb/tap_delay_line_tb_top.sv
`timescale 1ns/1ps
module tap_delay_line_tb_top;
  localparam int NWORDS = 12288 / 32;
  localparam int STEP   = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, bit_i = 1'b0, mute_i = 1'b0, slow_i = 1'b0;
  logic [2:0] code_i = 3'd0;
  logic bit_o, bit_vld_o, clear_done_o;

  typedef struct {logic b; string tag;} exp_t;
  exp_t sbq[$];
  exp_t mon_e;
  int checks = 0, failures = 0, k = 0;
  bit gpar = 1'b0, ph = 1'b0;
  bit hist [16384];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tap_delay_line dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bit_i(bit_i), .mute_i(mute_i),
    .slow_i(slow_i), .delay_code_i(code_i), .bit_o(bit_o),
    .bit_vld_o(bit_vld_o), .clear_done_o(clear_done_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // driver: ticks, pushing the expected bit of every sample
  task automatic drive(input int n, input bit running, input int off, input bit slow, input string tag);
    exp_t e;
    bit smp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bit_i  = lfsr[0];
      smp = slow ? ph : 1'b1;
      if (slow) ph = ~ph;
      if (smp) begin
        e.tag = tag;
        if (!running) e.b = gpar;
        else begin
          hist[k] = bit_i;
          if (k < off) begin e.b = k[0]; e.tag = "R5"; end
          else e.b = hist[k - off];
          k++;
        end
        gpar = ~gpar;
        sbq.push_back(e);
      end
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic full_clear(input logic [2:0] code, input logic slow);
    @(negedge clk);
    mute_i = 1'b1; code_i = code; slow_i = slow;
    repeat (NWORDS) @(negedge clk);
    chk("R2", clear_done_o, 1'b0, "done one edge early");
    @(negedge clk);
    chk("R2", clear_done_o, 1'b1, "done on 385th edge");
    mute_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", clear_done_o, 1'b1, "done held after release");
    k = 0; ph = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    chk(tag, logic'(sbq.size() == 0), 1'b1, "queue empty after run");
  endtask

  // monitor: compare each produced sample with the queue head
  always @(negedge clk) begin
    if (rst_n && bit_vld_o === 1'b1) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3 surplus sample actual=%0b expected=none", bit_o);
      end else begin
        mon_e = sbq.pop_front();
        chk(mon_e.tag, bit_o, mon_e.b, "sample bit");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", bit_vld_o, 1'b0, "reset valid");
    chk("R1", clear_done_o, 1'b0, "reset done");
    chk("R1", bit_o, 1'b0, "reset bit");

    drive(20, 1'b0, 0, 1'b0, "R1");
    drain("R1");

    // aborted clear: idle under mute and after an early release
    @(negedge clk); mute_i = 1'b1;
    repeat (50) @(negedge clk);
    drive(10, 1'b0, 0, 1'b0, "R8");
    chk("R8", clear_done_o, 1'b0, "done low mid-clear");
    mute_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", clear_done_o, 1'b0, "done low after abort");
    drive(10, 1'b0, 0, 1'b0, "R8");
    drain("R8");

    // fast, shortest tap, then an unmuted change that must be ignored
    full_clear(3'd0, 1'b0);
    drive(2300, 1'b1, STEP, 1'b0, "R3");
    @(negedge clk); code_i = 3'd5; slow_i = 1'b1;
    drive(1000, 1'b1, STEP, 1'b0, "R7");
    drain("R7");
    chk("R7", clear_done_o, 1'b1, "done kept through ignored change");

    // undefined code clamps to the 12000-cell tap
    full_clear(3'd7, 1'b0);
    drive(12600, 1'b1, 6 * STEP, 1'b0, "R4");
    drain("R4");

    // half rate, shortest tap: 2000 samples = 4000 ticks
    full_clear(3'd0, 1'b1);
    drive(4400, 1'b1, STEP, 1'b1, "R6");
    drain("R6");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule